// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This block gathers the completion and status events of an audio codec into one interrupt line. Five event sources arrive as single-cycle pulses: gain ramp-down done, gain ramp-up done, headphone ramp-down done, headphone ramp-up done and short-circuit. A sixth source comes from the headphone jack-present level. That level is asynchronous, so the block passes it through a two-flop synchroniser and treats every change of the synchronised level as an event. Each event sets a sticky flag. Software clears a flag by writing a one to its bit.

A control register holds two things. One is a per-source block field: a set bit keeps that source off the interrupt line. The other is a two-bit form field that chooses how the line behaves. It can be an active-high level, an active-low level, a one-cycle high pulse or a one-cycle low pulse. A pulse is issued whenever a flag becomes newly unmasked. The status read also returns the live synchronised jack level next to the latched flags.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset, all six flags read 0, the control register reads 0x3F (every source blocked, form 0), and `irq_o` is low.
- R2: A pulse on `evt_i` bit k sets status bit k on the next clock edge, whether or not the source is blocked. The bit order is: 0 gain ramp-down, 1 gain ramp-up, 2 headphone ramp-down, 3 headphone ramp-up, 4 short-circuit.
- R3: A status write (`wr_sel_i`=0) clears each flag in bits 5:0 whose data bit is 1. Flags whose data bit is 0 are left unchanged, and data bits 7:6 have no effect.
- R4: When an event and a clear reach the same flag in the same cycle, the flag stays set.
- R5: Status bit 6 returns the jack level after two synchronising flops and cannot be written. Every change of that synchronised level sets status bit 5 one cycle later.
- R6: In form 0 (control bits 7:6 = 0), `irq_o` is high exactly when some flag is set whose control bit 5:0 is 0.
- R7: In form 1, `irq_o` is the inverse of the form-0 level.
- R8: In form 2, `irq_o` is high for exactly one cycle. The pulse starts on the second clock edge after an unmasked flag becomes newly pending (the edge after the one that sets the flag) and ends on the third. A blocked flag gives no pulse.
- R9: In form 3, `irq_o` gives the same pulse as form 2 but active low, and rests high.
- R10: A control write (`wr_sel_i`=1) loads all eight bits, and the whole register reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | Single-cycle event pulses, bit order as in R2 |
| jack_i | input | 1 | Asynchronous jack-present level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (clear by one), 1 control |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 status, 1 control |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach is the collision where an event and a clear land on the same flag in the same cycle. The stimulus drives an event pulse and a status write in the same cycle, with write data that clears both the colliding bit and an idle bit. This shows that the set takes priority and that the clear still works on the other bit. The pulse forms are checked on exact cycles after an event: the bench steps cycle by cycle and samples the line before, during and after the pulse. The jack path is stepped one edge at a time so that the synchroniser delay and the latched change flag are checked separately.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;

    localparam int NUM_SRC   = 6;
    localparam int NUM_PULSE = NUM_SRC - 1;
    localparam int DATA_W    = 8;
    localparam int FORM_W    = 2;

    localparam int IDX_JACK_EVT  = 5;
    localparam int IDX_JACK_LIVE = 6;

    localparam logic SEL_STATUS  = 1'b0;
    localparam logic SEL_CONTROL = 1'b1;

    typedef enum logic [FORM_W-1:0] {
        FORM_LEVEL_HI = 2'd0,
        FORM_LEVEL_LO = 2'd1,
        FORM_PULSE_HI = 2'd2,
        FORM_PULSE_LO = 2'd3
    } irq_form_e;

    typedef struct packed {
        irq_form_e          form;
        logic [NUM_SRC-1:0] block;
    } irq_ctrl_t;

    localparam irq_ctrl_t CTRL_RESET = '{form: FORM_LEVEL_HI, block: '1};

    function automatic logic [DATA_W-1:0] pack_status(
        input logic               live,
        input logic [NUM_SRC-1:0] flags
    );
        logic [DATA_W-1:0] word;
        word = '0;
        word[NUM_SRC-1:0]   = flags;
        word[IDX_JACK_LIVE] = live;
        return word;
    endfunction

endpackage

// File: rtl/codec_jack_sync.sv
module codec_jack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic jack_async,
    output logic jack_live,
    output logic jack_change
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], jack_async};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign jack_live   = chain_q[STAGES-1];
    assign jack_change = chain_q[STAGES-1] ^ prev_q;

    AST_CHANGE_IS_EDGE: assert property (@(posedge clk) disable iff (rst)
        jack_change |=> (prev_q == $past(jack_live))) else $error("jack edge"); // R5

endmodule

// File: rtl/codec_flag_bank.sv
module codec_flag_bank
    import codec_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] flags_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (set_i[k])
                flag_q <= 1'b1;
            else if (clr_en_i && clr_bits_i[k])
                flag_q <= 1'b0;
        end
        assign flags_o[k] = flag_q;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))) else $error("set lost"); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        clr_en_i |=> ((flags_o & $past(clr_bits_i & ~set_i)) == '0)) else $error("clear lost"); // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0)) else $error("spurious flag"); // R2

endmodule

// File: rtl/codec_irq_shaper.sv
module codec_irq_shaper
    import codec_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] flags_i,
    input  irq_ctrl_t          ctrl_i,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] pend_q;
    logic               level;
    logic               pulse_q;

    assign pend  = flags_i & ~ctrl_i.block;
    assign level = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pend_q  <= pend;
            pulse_q <= |(pend & ~pend_q);
        end
    end

    always_comb begin
        unique case (ctrl_i.form)
            FORM_LEVEL_HI: irq_o = level;
            FORM_LEVEL_LO: irq_o = ~level;
            FORM_PULSE_HI: irq_o = pulse_q;
            FORM_PULSE_LO: irq_o = ~pulse_q;
            default:       irq_o = 1'b0;
        endcase
    end

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> ($past(pend) != '0)) else $error("pulse without source"); // R8
    AST_ALL_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_i.form == FORM_LEVEL_HI) && (&ctrl_i.block)) |-> !irq_o) else $error("blocked irq"); // R6

endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
    import codec_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PULSE-1:0] evt_i,
    input  logic                 jack_i,
    input  logic                 wr_en_i,
    input  logic                 wr_sel_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 rd_sel_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 irq_o
);
    logic               jack_live;
    logic               jack_change;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] set_vec;
    logic               clr_en;
    irq_ctrl_t          ctrl_q;

    codec_jack_sync #(.STAGES(2)) u_jack (
        .clk         (clk),
        .rst         (rst),
        .jack_async  (jack_i),
        .jack_live   (jack_live),
        .jack_change (jack_change)
    );

    assign set_vec = {jack_change, evt_i};
    assign clr_en  = wr_en_i && (wr_sel_i == SEL_STATUS);

    codec_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_vec),
        .clr_en_i   (clr_en),
        .clr_bits_i (wr_data_i[NUM_SRC-1:0]),
        .flags_o    (flags)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (wr_en_i && (wr_sel_i == SEL_CONTROL))
            ctrl_q <= irq_ctrl_t'(wr_data_i);
    end

    codec_irq_shaper u_shape (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .ctrl_i  (ctrl_q),
        .irq_o   (irq_o)
    );

    assign rd_data_o = (rd_sel_i == SEL_CONTROL) ? DATA_W'(ctrl_q)
                                                 : pack_status(jack_live, flags);

    AST_JACK_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$stable(jack_live) |=> flags[IDX_JACK_EVT]) else $error("jack flag"); // R5
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_CONTROL) |=> (DATA_W'(ctrl_q) == $past(wr_data_i))) else $error("ctrl load"); // R10

endmodule

// File: tb/test_codec_irq_unit.sv
module test_codec_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int KIND_STATUS = 0;
    localparam int KIND_CTRL = 1;
    localparam int KIND_IRQ = 2;

    typedef struct {
        int    kind;
        int    exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] evt = '0;
    logic       jack = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t sb_q[$];

    codec_irq_unit i_codec_irq_unit (
        .clk(clk), .rst(rst), .evt_i(evt), .jack_i(jack),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items half a cycle after each edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            int    act;
            it = sb_q.pop_front();
            rd_sel = (it.kind == KIND_CTRL);
            #1;
            act = (it.kind == KIND_IRQ) ? int'(irq) : int'(rd_data);
            n_checks++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input int exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic fire(input logic [4:0] bits);
        evt = bits; tick(); evt = '0;
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        expect_val(KIND_STATUS, 8'h00, "R1 flags after reset");
        expect_val(KIND_CTRL, 8'h3F, "R1 control after reset");
        expect_val(KIND_IRQ, 0, "R1 irq after reset");
        tick();

        fire(5'b10101);
        expect_val(KIND_STATUS, 8'h15, "R2 sources 0,2,4 latched while blocked");
        expect_val(KIND_IRQ, 0, "R6 blocked flags stay quiet");
        fire(5'b01010);
        expect_val(KIND_STATUS, 8'h1F, "R2 sources 1,3 latched");

        write_reg(1'b0, 8'h05);
        expect_val(KIND_STATUS, 8'h1A, "R3 ones clear bits 0,2");
        write_reg(1'b0, 8'hC0);
        expect_val(KIND_STATUS, 8'h1A, "R3 upper bits and zeros no effect");

        write_reg(1'b1, 8'h3D);
        expect_val(KIND_CTRL, 8'h3D, "R10 control readback");
        expect_val(KIND_IRQ, 1, "R6 unmasked flag 1 drives level");
        write_reg(1'b1, 8'h3E);
        expect_val(KIND_IRQ, 0, "R6 unmasked clear flag gives no irq");

        evt = 5'b00010;
        write_reg(1'b0, 8'h0A);
        evt = '0;
        expect_val(KIND_STATUS, 8'h12, "R4 set beats clear, other bit cleared");

        write_reg(1'b0, 8'h3F);
        expect_val(KIND_STATUS, 8'h00, "R3 clear all");

        jack = 1'b1;
        tick(); tick();
        expect_val(KIND_STATUS, 8'h40, "R5 live level after two flops");
        tick();
        expect_val(KIND_STATUS, 8'h60, "R5 jack change latched");
        write_reg(1'b0, 8'h60);
        expect_val(KIND_STATUS, 8'h40, "R5 live bit not writable");
        jack = 1'b0;
        repeat (3) tick();
        expect_val(KIND_STATUS, 8'h20, "R5 falling change latched");
        write_reg(1'b0, 8'h3F);

        write_reg(1'b1, 8'h7E);
        expect_val(KIND_IRQ, 1, "R7 active-low idle high");
        fire(5'b00001);
        expect_val(KIND_IRQ, 0, "R7 active-low asserted");
        write_reg(1'b0, 8'h01);
        expect_val(KIND_IRQ, 1, "R7 released after clear");

        write_reg(1'b1, 8'hBE);
        expect_val(KIND_IRQ, 0, "R8 pulse idle low");
        fire(5'b00001);
        expect_val(KIND_IRQ, 0, "R8 no pulse on set edge");
        tick();
        expect_val(KIND_IRQ, 1, "R8 pulse high");
        tick();
        expect_val(KIND_IRQ, 0, "R8 pulse one cycle");
        fire(5'b00100);
        tick();
        expect_val(KIND_IRQ, 0, "R8 blocked source no pulse");
        write_reg(1'b0, 8'h3F);

        write_reg(1'b1, 8'hFE);
        expect_val(KIND_IRQ, 1, "R9 low pulse idle high");
        fire(5'b00001);
        tick();
        expect_val(KIND_IRQ, 0, "R9 low pulse");
        tick();
        expect_val(KIND_IRQ, 1, "R9 low pulse one cycle");

        tick(); tick();
        done = 1;
        summary();
    end
endmodule